// File: doc/BRIEF.md
# Host-Loadable Registered Output Cell Bank

This block holds a bank of registered logic cells. In normal operation each cell's flip-flop is driven by terms from a programmable logic array: a data term, a capture term that acts as the cell's clock, a synchronous preset and a synchronous clear. A host processor can also reach the bank through a memory-mapped bus. A host write loads the cells with bus data and wins over every array term on that edge. A host read returns the cell contents. This suits loadable counters, shift registers, mailboxes and handshake flags that both the logic array and software touch.

Each cell also has a pin output enable. Its term from the array is ORed with that pin's direction bit. A cell that is set up as an internal node never enables its pin, and its state is still available as feedback to the array. Some cells may have no enable term at all. For those cells the parameter `OE_DEF` has a 0, and the pin is enabled whenever the cell is not an internal node.

Top module: `mcell_bank`

## Requirements
- R1: While reset is asserted and after it is released, every cell reads 0 until a load or an array term changes it.
- R2: A host write to byte 0 (`host_we`=1, `host_sel`=1, `host_addr`=0) loads cell i from `host_wdata[i]`, for i from 0 to 7, on that clock edge.
- R3: A host write to byte 1 (`host_addr`=1) loads cells 8 to 11 from `host_wdata[3:0]`. Bits 7:4 of the data have no effect.
- R4: A load has priority over clear, preset and the capture term for the cells it addresses. Cells that the write does not address follow their array terms on the same edge.
- R5: When no load addresses the cell, clear high sets the cell to 0 on the next edge. Clear wins over preset.
- R6: When no load addresses the cell and clear is low, preset high sets the cell to 1 on the next edge.
- R7: When there is no load, no clear and no preset, a high capture term stores the data term on the edge. With the capture term low, the cell holds its value.
- R8: Readback is combinational. With `host_sel`=1 and `host_addr`=0, `host_rdata` equals cells 7:0. With `host_addr`=1 it equals {4'b0, cells 11:8}. With `host_sel`=0 it is 0.
- R9: `pin_oe[i]` is 0 when `node_cfg[i]`=1. Otherwise it is `dir_bits[i]` OR the enable term. The enable term is `oe_term[i]` when `OE_DEF[i]`=1 and a constant 1 when `OE_DEF[i]`=0.
- R10: A write strobe while `host_sel` is 0 loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| arr_d | input | 12 | Data term per cell |
| arr_ck | input | 12 | Capture (clock) term per cell |
| arr_pr | input | 12 | Synchronous preset term per cell |
| arr_clr | input | 12 | Synchronous clear term per cell |
| host_we | input | 1 | Host write strobe, sampled on clk |
| host_sel | input | 1 | Address match for the cell bank |
| host_addr | input | 1 | Byte select within the bank |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host readback data |
| dir_bits | input | 12 | Direction register bit per pin |
| oe_term | input | 12 | Output-enable term per pin |
| node_cfg | input | 12 | 1 marks a cell as an internal node |
| cell_q | output | 12 | Cell states, also the feedback to the array |
| pin_oe | output | 12 | Pin output enable |

## Verification
The cell assertions assume that every array term and host signal is stable around the rising edge, because they relate one edge's inputs to the next cycle's state. The bench changes all inputs only on the falling edge. The readback assertion assumes `host_addr` never selects a byte beyond the bank. The bench drives only byte 0 and byte 1. Each phase of the stimulus raises one group of terms with random data while the others stay low or random. This covers every priority case, including a load, clear, preset and capture all high in the same cycle.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int MC_BYTE_W = 8;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_LOAD,
    ACT_CLEAR,
    ACT_PRESET,
    ACT_CAPTURE
  } cell_act_e;
endpackage

// File: rtl/mcell_rst_sync.sv
module mcell_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mcell_ff.sv
module mcell_ff
  import mcell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic ld_val,
  input  logic d,
  input  logic ck,
  input  logic pr,
  input  logic clr,
  output logic q
);
  cell_act_e act;
  logic      q_nxt;

  // Priority: host load, then clear, then preset, then capture.
  always_comb begin
    if (ld)       act = ACT_LOAD;
    else if (clr) act = ACT_CLEAR;
    else if (pr)  act = ACT_PRESET;
    else if (ck)  act = ACT_CAPTURE;
    else          act = ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      ACT_LOAD:    q_nxt = ld_val;
      ACT_CLEAR:   q_nxt = 1'b0;
      ACT_PRESET:  q_nxt = 1'b1;
      ACT_CAPTURE: q_nxt = d;
      default:     q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(ld_val)));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && clr) |=> !q);
  a_r6_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !clr && pr) |=> q);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !clr && !pr && !ck) |=> $stable(q));
endmodule

// File: rtl/mcell_rdmux.sv
module mcell_rdmux #(
  parameter int NCELL = 12,
  parameter int BW    = 8,
  parameter int NBYTE = 2,
  parameter int ABW   = 1
) (
  input  logic [NCELL-1:0] q,
  input  logic             sel,
  input  logic [ABW-1:0]   addr,
  output logic [BW-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    if (sel) begin
      for (int k = 0; k < NBYTE; k++) begin
        if (addr == ABW'(k)) begin
          for (int b = 0; b < BW; b++) begin
            if (k * BW + b < NCELL) rdata[b] = q[k * BW + b];
          end
        end
      end
    end
  end
endmodule

// File: rtl/mcell_oe.sv
module mcell_oe #(
  parameter int               NCELL  = 12,
  parameter logic [NCELL-1:0] OE_DEF = '1
) (
  input  logic [NCELL-1:0] dir_bits,
  input  logic [NCELL-1:0] oe_term,
  input  logic [NCELL-1:0] node_cfg,
  output logic [NCELL-1:0] pin_oe
);
  for (genvar i = 0; i < NCELL; i++) begin : g_oe
    if (OE_DEF[i]) begin : g_term
      assign pin_oe[i] = !node_cfg[i] && (dir_bits[i] || oe_term[i]);
    end else begin : g_always
      logic unused_term;
      assign unused_term = oe_term[i] ^ dir_bits[i];
      assign pin_oe[i]   = !node_cfg[i];
    end
  end
endmodule

// File: rtl/mcell_bank.sv
module mcell_bank
  import mcell_pkg::*;
#(
  parameter int               NCELL  = 12,
  parameter logic [NCELL-1:0] OE_DEF = 12'h0FF,
  localparam int              NBYTE  = (NCELL + MC_BYTE_W - 1) / MC_BYTE_W,
  localparam int              ABW    = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCELL-1:0]     arr_d,
  input  logic [NCELL-1:0]     arr_ck,
  input  logic [NCELL-1:0]     arr_pr,
  input  logic [NCELL-1:0]     arr_clr,
  input  logic                 host_we,
  input  logic                 host_sel,
  input  logic [ABW-1:0]       host_addr,
  input  logic [MC_BYTE_W-1:0] host_wdata,
  output logic [MC_BYTE_W-1:0] host_rdata,
  input  logic [NCELL-1:0]     dir_bits,
  input  logic [NCELL-1:0]     oe_term,
  input  logic [NCELL-1:0]     node_cfg,
  output logic [NCELL-1:0]     cell_q,
  output logic [NCELL-1:0]     pin_oe
);
  localparam int TAIL = NCELL - (NBYTE - 1) * MC_BYTE_W;

  logic rst_i_n;
  logic wr_en;

  mcell_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign wr_en = host_we && host_sel;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic ld;
    assign ld = wr_en && (host_addr == ABW'(i / MC_BYTE_W));

    mcell_ff u_ff (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .ld     (ld),
      .ld_val (host_wdata[i % MC_BYTE_W]),
      .d      (arr_d[i]),
      .ck     (arr_ck[i]),
      .pr     (arr_pr[i]),
      .clr    (arr_clr[i]),
      .q      (cell_q[i])
    );
  end

  mcell_rdmux #(
    .NCELL (NCELL),
    .BW    (MC_BYTE_W),
    .NBYTE (NBYTE),
    .ABW   (ABW)
  ) u_rd (
    .q     (cell_q),
    .sel   (host_sel),
    .addr  (host_addr),
    .rdata (host_rdata)
  );

  mcell_oe #(
    .NCELL  (NCELL),
    .OE_DEF (OE_DEF)
  ) u_oe (
    .dir_bits (dir_bits),
    .oe_term  (oe_term),
    .node_cfg (node_cfg),
    .pin_oe   (pin_oe)
  );

  // R8: bits past the last cell in the top byte always read as zero.
  if (TAIL < MC_BYTE_W) begin : g_tail_chk
    a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
      (host_addr == ABW'(NBYTE - 1)) |-> (host_rdata[MC_BYTE_W-1:TAIL] == '0));
  end

  // R10: with no address match, a write strobe leaves a held cell unchanged.
  a_r10_no_sel: assert property (@(posedge clk) disable iff (!rst_i_n)
    (host_we && !host_sel && !arr_clr[0] && !arr_pr[0] && !arr_ck[0])
      |=> $stable(cell_q[0]));
endmodule

// File: tb/tb_mcell_bank.sv
module tb_mcell_bank;
  localparam int         CLK_P = 10;
  localparam int         N     = 12;
  localparam logic [N-1:0] OEM = 12'h0FF;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] arr_d, arr_ck, arr_pr, arr_clr;
  logic         host_we, host_sel;
  logic [0:0]   host_addr;
  logic [7:0]   host_wdata, host_rdata;
  logic [N-1:0] dir_bits, oe_term, node_cfg, cell_q, pin_oe;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] mq;
  string tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  mcell_bank #(.NCELL(N), .OE_DEF(OEM)) dut (
    .clk(clk), .rst_n(rst_n), .arr_d(arr_d), .arr_ck(arr_ck),
    .arr_pr(arr_pr), .arr_clr(arr_clr), .host_we(host_we),
    .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dir_bits(dir_bits), .oe_term(oe_term),
    .node_cfg(node_cfg), .cell_q(cell_q), .pin_oe(pin_oe)
  );

  // Reference model: one behavioural update per rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mq <= '0;
    else begin
      for (int i = 0; i < N; i++) begin
        bit hit;
        hit = host_we && host_sel && (int'(host_addr) == i / 8);
        if (hit)             mq[i] <= host_wdata[i % 8];
        else if (arr_clr[i]) mq[i] <= 1'b0;
        else if (arr_pr[i])  mq[i] <= 1'b1;
        else if (arr_ck[i])  mq[i] <= arr_d[i];
      end
    end
  end

  function automatic logic [7:0] exp_rd();
    if (!host_sel)     return 8'h00;
    if (host_addr == 0) return mq[7:0];
    return {4'h0, mq[11:8]};
  endfunction

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (node_cfg[i]) r[i] = 1'b0;
      else r[i] = dir_bits[i] | (OEM[i] ? oe_term[i] : 1'b1);
    end
    return r;
  endfunction

  task automatic check_all();
    checks++;
    if (cell_q !== mq) begin
      fails++;
      $display("FAIL %s cell_q act=%h exp=%h", tag, cell_q, mq);
    end
    checks++;
    if (host_rdata !== exp_rd()) begin
      fails++;
      $display("FAIL %s host_rdata act=%h exp=%h (R8)", tag, host_rdata, exp_rd());
    end
    checks++;
    if (pin_oe !== exp_oe()) begin
      fails++;
      $display("FAIL %s pin_oe act=%h exp=%h (R9)", tag, pin_oe, exp_oe());
    end
  endtask

  task automatic idle();
    arr_d = '0; arr_ck = '0; arr_pr = '0; arr_clr = '0;
    host_we = 0; host_sel = 0; host_addr = 0; host_wdata = '0;
    dir_bits = '0; oe_term = '0; node_cfg = '0;
  endtask

  // Drive one phase of cycles; mode picks which inputs are randomised.
  task automatic run_phase(string t, int mode, int ncyc);
    tag = t;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      check_all();
      idle();
      host_sel  = $urandom_range(0, 1);
      host_addr = 1'($urandom_range(0, 1));
      dir_bits  = N'($urandom); oe_term = N'($urandom); node_cfg = N'($urandom);
      arr_d     = N'($urandom);
      case (mode)
        2: begin host_we = 1; host_sel = 1; host_addr = 0; host_wdata = 8'($urandom);
                 arr_ck = N'($urandom); end
        3: begin host_we = 1; host_sel = 1; host_addr = 1; host_wdata = 8'($urandom);
                 arr_ck = N'($urandom); end
        4: begin host_we = 1; host_sel = 1; host_addr = 1'($urandom_range(0, 1));
                 host_wdata = 8'($urandom); arr_clr = '1; arr_pr = '1; arr_ck = '1; end
        5: begin arr_clr = N'($urandom); arr_pr = N'($urandom); arr_ck = N'($urandom); end
        6: begin arr_pr = N'($urandom); arr_ck = N'($urandom); end
        7: begin arr_ck = N'($urandom); end
        10: begin host_we = 1; host_sel = 0; host_wdata = 8'($urandom); end
        default: begin
          host_we = $urandom_range(0, 1); host_wdata = 8'($urandom);
          arr_clr = N'($urandom) & N'($urandom); arr_pr = N'($urandom) & N'($urandom);
          arr_ck = N'($urandom);
        end
      endcase
    end
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_all();                // R1: state during reset
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all();                // R1: state after release
    repeat (2) @(negedge clk);
    run_phase("R2", 2, 40);
    run_phase("R3", 3, 40);
    run_phase("R10", 10, 40);
    run_phase("R4", 4, 40);
    run_phase("R6", 6, 40);
    run_phase("R5", 5, 40);
    run_phase("R7", 7, 40);
    run_phase("R8", 7, 30);
    run_phase("R9", 0, 30);
    run_phase("R4", 0, 200);
    @(negedge clk);
    check_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule